// File: doc/BRIEF.md
# CPU/PCI Bus Arbiter With Tenure Timer

This block decides which agent owns a shared PCI bus: a host CPU agent or one of several PCI request lines. Each agent raises its request line and receives a one-hot grant. PCI agents are served in round-robin order. The CPU is slotted in after a configurable number of PCI grants, two or three, chosen by a priority bit.

An 8-bit tenure value gives the minimum number of clocks an owner keeps the grant while it is still requesting. Once that time has elapsed, any other pending request makes the arbiter release the bus. Every change of owner passes through exactly one clock in which no grant is asserted. In that idle clock the arbiter samples the requests and picks the next owner. When nobody requests, the bus is parked on the CPU.

Top module: `bus_tenure_arbiter`

## Requirements
- R1: At most one of `cpu_gnt` and the bits of `pci_gnt` is high in any cycle.
- R2: Between two different owners there is exactly one clock with no grant asserted, and a grant-free clock is always followed by a grant in the next clock.
- R3: While `rst_n` is low, `cpu_gnt` is 1 and `pci_gnt` is all zeros.
- R4: An owner whose request stays high keeps its grant for at least max(`mtt`,1) consecutive clocks. A lone owner keeps it with no time limit.
- R5: In a grant clock where the owner has held the grant for at least `mtt` clocks (this clock included) and another agent is requesting, the grant drops in the next clock.
- R6: A PCI owner whose request is low in a grant clock loses the grant in the next clock. A CPU owner whose request is low loses it in the next clock if any PCI request is high.
- R7: In the idle clock, if no request is high, the CPU receives the grant in the next clock (parking).
- R8: When a PCI agent is chosen, it is the first requesting agent found by searching upward in index from the last PCI agent granted, wrapping from NUM_AGENTS-1 to 0. After reset the search starts at index 0.
- R9: In the idle clock, a requesting CPU wins if the number of PCI grants since its last grant has reached the limit, or if no PCI agent requests. The limit is 2 when `cpu_prio` is 1 and 3 when it is 0. Otherwise a requesting PCI agent wins.
- R10: Only an actual PCI grant adds to the count of R9. Every CPU grant, parking included, clears the count.
- R11: With `mtt` equal to 0 or 1, a preempted owner holds the grant for exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Host CPU agent requests the bus |
| pci_req | input | NUM_AGENTS | Per-agent PCI request lines |
| cpu_prio | input | 1 | 1: CPU after two PCI grants; 0: after three |
| mtt | input | TMR_W | Guaranteed tenure in clocks |
| cpu_gnt | output | 1 | Grant to the host CPU agent |
| pci_gnt | output | NUM_AGENTS | One-hot grants to the PCI agents |

## Verification
Two decisions can meet in one clock. The tenure expiry that would preempt an owner can coincide with that owner dropping its request. In the idle clock, the CPU insertion count can come due while a PCI agent is also requesting. The bench provokes both by toggling request lines at random while all agents are busy, with small `mtt` values and `cpu_prio` switching. A cycle-level reference model computes the grant each clock and labels every expected grant with the rule that decided it, so a miscompare points to the rule involved.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;
  typedef enum logic {PH_HOLD = 1'b0, PH_GAP = 1'b1} phase_t;
endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int NUM_AGENTS = 4,
  parameter int IDX_W      = 2
) (
  input  logic [NUM_AGENTS-1:0] req,
  input  logic [IDX_W-1:0]      last_idx,
  output logic                  any,
  output logic [IDX_W-1:0]      pick_idx
);
  always_comb begin
    any      = 1'b0;
    pick_idx = last_idx;
    for (int k = NUM_AGENTS; k >= 1; k--) begin
      int j;
      j = int'(last_idx) + k;
      if (j >= NUM_AGENTS) j = j - NUM_AGENTS;
      if (req[j]) begin
        any      = 1'b1;
        pick_idx = IDX_W'(j);
      end
    end
  end
endmodule

// File: rtl/arb_tenure_ctr.sv
module arb_tenure_ctr #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             inc,
  input  logic [TMR_W-1:0] limit,
  output logic             done
);
  localparam logic [TMR_W-1:0] CNT_MAX = '1;
  logic [TMR_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load | (inc & (cnt_q != CNT_MAX));
    cnt_d  = load ? TMR_W'(1) : cnt_q + TMR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= TMR_W'(1);
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q >= limit);
endmodule

// File: rtl/arb_slot_ctr.sv
module arb_slot_ctr (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  input  logic two_slots,
  output logic due
);
  logic [1:0] cnt_q, cnt_d;
  logic       cnt_en;

  always_comb begin
    cnt_en = clr | (inc & (cnt_q != 2'd3));
    cnt_d  = clr ? 2'd0 : cnt_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= 2'd0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign due = two_slots ? (cnt_q >= 2'd2) : (cnt_q == 2'd3);
endmodule

// File: rtl/bus_tenure_arbiter.sv
module bus_tenure_arbiter #(
  parameter int NUM_AGENTS = 4,
  parameter int TMR_W      = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cpu_req,
  input  logic [NUM_AGENTS-1:0] pci_req,
  input  logic                  cpu_prio,
  input  logic [TMR_W-1:0]      mtt,
  output logic                  cpu_gnt,
  output logic [NUM_AGENTS-1:0] pci_gnt
);
  import bus_arb_pkg::*;
  localparam int IDX_W = (NUM_AGENTS > 1) ? $clog2(NUM_AGENTS) : 1;

  phase_t                  phase_q, phase_d;
  logic                    own_cpu_q, own_cpu_d;
  logic [IDX_W-1:0]        last_q, last_d;
  logic [NUM_AGENTS-1:0]   own_mask;
  logic                    own_req, other_req;
  logic                    rr_any;
  logic [IDX_W-1:0]        rr_idx;
  logic                    ten_load, ten_inc, ten_done;
  logic                    slot_clr, slot_inc, slot_due;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_AGENTS; gi++) begin : g_mask
      assign own_mask[gi] = (last_q == IDX_W'(gi));
      assign pci_gnt[gi]  = (phase_q == PH_HOLD) && !own_cpu_q && own_mask[gi];
    end
  endgenerate
  assign cpu_gnt = (phase_q == PH_HOLD) && own_cpu_q;

  arb_rr_pick #(.NUM_AGENTS(NUM_AGENTS), .IDX_W(IDX_W)) u_rr (
    .req(pci_req), .last_idx(last_q), .any(rr_any), .pick_idx(rr_idx));

  arb_tenure_ctr #(.TMR_W(TMR_W)) u_ten (
    .clk(clk), .rst_n(rst_n), .load(ten_load), .inc(ten_inc),
    .limit(mtt), .done(ten_done));

  arb_slot_ctr u_slot (
    .clk(clk), .rst_n(rst_n), .clr(slot_clr), .inc(slot_inc),
    .two_slots(cpu_prio), .due(slot_due));

  always_comb begin
    own_req   = own_cpu_q ? cpu_req : |(pci_req & own_mask);
    other_req = own_cpu_q ? |pci_req : (cpu_req | |(pci_req & ~own_mask));
    phase_d   = phase_q;
    own_cpu_d = own_cpu_q;
    last_d    = last_q;
    ten_load  = 1'b0;
    ten_inc   = 1'b0;
    slot_clr  = 1'b0;
    slot_inc  = 1'b0;
    case (phase_q)
      PH_HOLD: begin
        if ((other_req && (!own_req || ten_done)) || (!own_cpu_q && !own_req))
          phase_d = PH_GAP;
        else
          ten_inc = 1'b1;
      end
      default: begin
        phase_d  = PH_HOLD;
        ten_load = 1'b1;
        if (rr_any && !(cpu_req && slot_due)) begin
          own_cpu_d = 1'b0;
          last_d    = rr_idx;
          slot_inc  = 1'b1;
        end else begin
          own_cpu_d = 1'b1;
          slot_clr  = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_HOLD;
      own_cpu_q <= 1'b1;
      last_q    <= IDX_W'(NUM_AGENTS - 1);
    end else begin
      phase_q   <= phase_d;
      own_cpu_q <= own_cpu_d;
      last_q    <= last_d;
    end
  end
endmodule

// File: rtl/bus_arb_checker.sv
module bus_arb_checker #(
  parameter int NUM_AGENTS = 4,
  parameter int TMR_W      = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cpu_req,
  input logic [NUM_AGENTS-1:0] pci_req,
  input logic [TMR_W-1:0]      mtt,
  input logic                  cpu_gnt,
  input logic [NUM_AGENTS-1:0] pci_gnt
);
  localparam int GW = NUM_AGENTS + 1;
  logic [GW-1:0]    g, prev_g;
  logic [TMR_W:0]   hold_q, held_now;
  logic             own_req_now, no_req;

  assign g           = {cpu_gnt, pci_gnt};
  assign own_req_now = |(g & {cpu_req, pci_req});
  assign no_req      = !cpu_req && (pci_req == '0);
  assign held_now    = ((g == prev_g) && (g != '0)) ?
                       ((hold_q == '1) ? hold_q : hold_q + 1'b1) : (TMR_W+1)'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_g <= '0;
      hold_q <= '0;
    end else begin
      prev_g <= g;
      hold_q <= held_now;
    end
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(g)); // R1
  AST_GAP_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (g != '0) |=> ((g == $past(g)) || (g == '0))); // R2
  AST_GAP_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (g == '0) |=> (g != '0)); // R2
  AST_TENURE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ((g != '0) && own_req_now && (held_now < {1'b0, mtt})) |=> (g == $past(g))); // R4
  AST_PARK_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    ((g == '0) && no_req) |=> cpu_gnt); // R7
endmodule

bind bus_tenure_arbiter bus_arb_checker #(.NUM_AGENTS(NUM_AGENTS), .TMR_W(TMR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .pci_req(pci_req), .mtt(mtt),
  .cpu_gnt(cpu_gnt), .pci_gnt(pci_gnt));

// File: tb/sim_bus_tenure_arbiter.sv
module sim_bus_tenure_arbiter;
  localparam int N  = 4;
  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_req = 1'b0;
  logic [N-1:0]  pci_req = '0;
  logic          cpu_prio = 1'b1;
  logic [TW-1:0] mtt = '0;
  logic          cpu_gnt;
  logic [N-1:0]  pci_gnt;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  bus_tenure_arbiter #(.NUM_AGENTS(N), .TMR_W(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .pci_req(pci_req),
    .cpu_prio(cpu_prio), .mtt(mtt), .cpu_gnt(cpu_gnt), .pci_gnt(pci_gnt));

  // Reference model state
  bit    m_hold, m_cpu;
  int    m_last, m_cnt, m_sc;
  string m_why;

  function automatic int rr_next(int last, logic [N-1:0] req);
    for (int k = 1; k <= N; k++) begin
      int j = (last + k) % N;
      if (req[j]) return j;
    end
    return -1;
  endfunction

  function automatic logic [N:0] exp_grant();
    logic [N:0] e = '0;
    if (m_hold) begin
      if (m_cpu) e[N] = 1'b1;
      else       e[m_last] = 1'b1;
    end
    return e;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hold = 1; m_cpu = 1; m_last = N - 1; m_cnt = 1; m_sc = 0; m_why = "R3";
    end else if (m_hold) begin
      bit own, oth;
      own = m_cpu ? cpu_req : pci_req[m_last];
      oth = m_cpu ? (|pci_req) : (cpu_req || ((pci_req & ~(N'(1) << m_last)) != '0));
      if (!m_cpu && !own) begin
        m_hold = 0; m_why = "R6";
      end else if (oth && !own) begin
        m_hold = 0; m_why = "R6";
      end else if (oth && m_cnt >= int'(mtt)) begin
        m_hold = 0; m_why = (mtt <= 1) ? "R11" : "R5";
      end else begin
        if (m_cnt < 255) m_cnt++;
        m_why = "R4";
      end
    end else begin
      int p;
      int lim;
      p   = rr_next(m_last, pci_req);
      lim = cpu_prio ? 2 : 3;
      m_hold = 1; m_cnt = 1;
      if (p >= 0 && !(cpu_req && m_sc >= lim)) begin
        m_cpu = 0; m_last = p; if (m_sc < 3) m_sc++; m_why = "R8";
      end else begin
        m_cpu = 1; m_sc = 0;
        m_why = (cpu_req) ? "R9 R10" : "R7";
      end
    end
  end

  logic [N:0] prev_act = '0;
  bit         have_prev = 1'b0;

  task automatic check_cycle();
    logic [N:0] act = {cpu_gnt, pci_gnt};
    logic [N:0] exp = exp_grant();
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: grant {cpu,pci} got %b expected %b", m_why, act, exp);
    end
    vectors++;
    if ($countones(act) > 1) begin
      fails++;
      $display("FAIL R1: grant {cpu,pci} got %b expected at most one bit", act);
    end
    if (have_prev) begin
      vectors++;
      if ((prev_act != '0 && act != '0 && act != prev_act) ||
          (prev_act == '0 && act == '0)) begin
        fails++;
        $display("FAIL R2: grant {cpu,pci} got %b after %b expected one idle clock", act, prev_act);
      end
    end
    prev_act  = act;
    have_prev = 1'b1;
  endtask

  task automatic run_cycles(int n, bit rnd);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_cycle();
      if (rnd) begin
        if ($urandom_range(0, 3) == 0) cpu_req = ~cpu_req;
        for (int a = 0; a < N; a++)
          if ($urandom_range(0, 4) == 0) pci_req[a] = ~pci_req[a];
        if ($urandom_range(0, 40) == 0) cpu_prio = ~cpu_prio;
        if ($urandom_range(0, 60) == 0) mtt = TW'($urandom_range(0, 6));
      end
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (2) @(negedge clk);
    // R3: reset state
    vectors++;
    if (cpu_gnt !== 1'b1 || pci_gnt !== '0) begin
      fails++;
      $display("FAIL R3: grant {cpu,pci} got %b expected %b", {cpu_gnt, pci_gnt}, {1'b1, N'(0)});
    end
    rst_n = 1'b1;
    // R8 R9: everyone busy, two-slot CPU insertion, tenure 4 (R4 R5)
    cpu_req = 1; pci_req = '1; cpu_prio = 1; mtt = 4;
    run_cycles(60, 0);
    // R9: three-slot insertion
    cpu_prio = 0;
    run_cycles(60, 0);
    // R11: zero tenure under full contention
    mtt = 0;
    run_cycles(30, 0);
    // R7: no requests, park on CPU
    cpu_req = 0; pci_req = '0;
    run_cycles(10, 0);
    // R10: sparse PCI traffic, parked CPU grants clear the slot count
    pci_req = 4'b0100; mtt = 2;
    run_cycles(8, 0);
    pci_req = '0;
    run_cycles(6, 0);
    cpu_req = 1; pci_req = 4'b0011;
    run_cycles(30, 0);
    // R6: owner drops request before long tenure expires
    mtt = 200;
    run_cycles(10, 0);
    pci_req = '0; cpu_req = 1;
    run_cycles(6, 0);
    pci_req = 4'b1000; cpu_req = 0;
    run_cycles(10, 0);
    // mixed random traffic
    mtt = 3;
    run_cycles(4000, 1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run got no end expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule